// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns one asynchronous serial line into parallel words. It has no clock from the far end. A prescaler derives a sample tick from the local clock, with sixteen ticks to each bit period. The prescaler restarts on the falling edge that opens each frame, so every frame is timed from its own start edge. Each bit is taken at its midpoint.

Data width, parity and stop length are set at run time from static inputs. Each completed frame produces a one-cycle valid pulse. With it come the word, a parity-error flag and a framing-error flag. A packet-end flag is raised when the word matches a programmed terminator value, such as a line feed, a carriage return, 0x00 or 0xFF.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `valid_o`, `eop_o`, `parity_err_o` and `frame_err_o` are 0 and `word_o` is 0.
- R2: The line idles high. A low level starts a candidate frame, and the start bit is resampled 8 ticks later. A low that has gone high again by then is dropped and produces no word.
- R3: A sample tick occurs once every `divisor_i` clocks (a value of 0 is treated as 1). One bit period is 16 ticks.
- R4: `width_sel_i` picks the data width: 0 gives 7 bits, 1 gives 8, 2 or 3 give 9. Bits arrive LSB first and fill `word_o` from bit 0. Word bits above the width read 0.
- R5: When `par_en_i` is 1, one parity bit follows the data. `par_odd_i`=0 selects even parity and 1 selects odd. A mismatch sets `parity_err_o` with the word. With parity off, `parity_err_o` is 0.
- R6: `stop_sel_i` picks the stop length: 0 gives 1 bit, 1 gives 1.5 bits (24 ticks), 2 or 3 give 2 bits. The line is sampled at the middle of the first stop bit and at the middle of the final stop half or bit. A low at either sample sets `frame_err_o`.
- R7: After a framing error the receiver waits for the line to go high before it looks for a new start bit. A line held low after a bad stop produces no extra word.
- R8: Each frame gives exactly one single-cycle `valid_o` pulse. `word_o` and both error flags hold their values until the next frame completes.
- R9: `eop_o` pulses together with `valid_o` when the received word, zero-extended to 9 bits, equals `term_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, asynchronous |
| divisor_i | input | DIV_W | Clocks per sample tick |
| width_sel_i | input | 2 | Data width select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1 |
| stop_sel_i | input | 2 | Stop length select |
| term_i | input | 9 | Packet terminator value |
| word_o | output | 9 | Received word |
| valid_o | output | 1 | Word complete pulse |
| parity_err_o | output | 1 | Parity mismatch on the word |
| frame_err_o | output | 1 | Low seen during the stop period |
| eop_o | output | 1 | Word equals the terminator |

## Verification
The bench sends random frames across all widths, parity modes, stop lengths and tick divisors, with some parity and stop errors injected. A receiver with a wrong mid-bit offset or a wrong 1.5-bit stop timing would shift bits or misreport the stop. Errors in data width or bit order show up as wrong or unmasked words. A short low pulse on the idle line checks that a false start yields no word. A line held low after a bad stop checks that a receiver which restarts at once would emit a spurious word. The bench also checks that terminator hits raise the packet-end flag and that the output word holds between frames.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [1:0]       width_sel_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic [1:0]       stop_sel_i,
  input  logic [8:0]       term_i,
  output logic [8:0]       word_o,
  output logic             valid_o,
  output logic             parity_err_o,
  output logic             frame_err_o,
  output logic             eop_o
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [DIV_W-1:0] pcnt;
  logic [4:0]       scnt;
  logic [3:0]       bcnt;
  logic [8:0]       sh;
  logic             pbit, ferr;

  wire              rx_s    = sync[1];
  wire [DIV_W-1:0]  div_m1  = (divisor_i == '0) ? '0 : divisor_i - 1'b1;
  wire              tick    = (pcnt == div_m1);
  wire [3:0]        last_b  = (width_sel_i == 2'd0) ? 4'd6 : (width_sel_i == 2'd1) ? 4'd7 : 4'd8;
  wire [4:0]        last_s  = (stop_sel_i == 2'd0) ? 5'd15 : (stop_sel_i == 2'd1) ? 5'd27 : 5'd31;
  wire              bad_end = ferr | ~rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sync <= 2'b11; pcnt <= '0; scnt <= '0; bcnt <= '0;
      sh <= '0; pbit <= 1'b0; ferr <= 1'b0;
      word_o <= '0; valid_o <= 1'b0; parity_err_o <= 1'b0;
      frame_err_o <= 1'b0; eop_o <= 1'b0;
    end else begin
      sync    <= {sync[0], rx_i};
      valid_o <= 1'b0;
      eop_o   <= 1'b0;
      if (st == S_IDLE) pcnt <= '0;
      else              pcnt <= tick ? '0 : pcnt + 1'b1;
      case (st)
        S_IDLE: if (!rx_s) begin st <= S_START; scnt <= '0; end
        S_START: if (tick) begin
          if (scnt == 5'd7) begin
            if (!rx_s) begin
              st <= S_DATA; scnt <= '0; bcnt <= '0; sh <= '0; ferr <= 1'b0; pbit <= 1'b0;
            end else st <= S_IDLE;
          end else scnt <= scnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (scnt == 5'd15) begin
            sh[bcnt] <= rx_s;
            scnt     <= '0;
            if (bcnt == last_b) st <= par_en_i ? S_PAR : S_STOP;
            else                bcnt <= bcnt + 1'b1;
          end else scnt <= scnt + 1'b1;
        end
        S_PAR: if (tick) begin
          if (scnt == 5'd15) begin
            pbit <= rx_s; scnt <= '0; st <= S_STOP;
          end else scnt <= scnt + 1'b1;
        end
        S_STOP: if (tick) begin
          scnt <= scnt + 1'b1;
          if (scnt == 5'd15 && !rx_s) ferr <= 1'b1;
          if (scnt == last_s) begin
            word_o       <= sh;
            parity_err_o <= par_en_i & (^sh ^ pbit ^ par_odd_i);
            frame_err_o  <= bad_end;
            eop_o        <= (sh == term_i);
            valid_o      <= 1'b1;
            st           <= bad_end ? S_WAITH : S_IDLE;
          end
        end
        S_WAITH: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o);
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(word_o) |-> valid_o);
  // R9
  eop_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) eop_o |-> valid_o);
  // R7
  wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITH && !rx_s) |=> (st == S_WAITH));
  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_s) |=> (st == S_IDLE));
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [15:0] div = 16'd4;
  logic [1:0] wsel = 2'd1, ssel = 2'd0;
  logic       pen = 1'b0, podd = 1'b0;
  logic [8:0] term = 9'h00A;
  logic [8:0] word;
  logic       valid, perr, ferr, eop;

  int checks = 0, fails = 0, vcnt = 0;
  logic [8:0] cap_w;
  logic cap_p, cap_f, cap_e;
  bit done = 0;

  always #5 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .divisor_i(div), .width_sel_i(wsel),
    .par_en_i(pen), .par_odd_i(podd), .stop_sel_i(ssel), .term_i(term),
    .word_o(word), .valid_o(valid), .parity_err_o(perr), .frame_err_o(ferr), .eop_o(eop));

  always @(negedge clk) if (valid) begin
    vcnt++; cap_w = word; cap_p = perr; cap_f = ferr; cap_e = eop;
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd1) ? 8 : 9;
  endfunction
  function automatic int stop_ticks(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction
  function automatic logic [8:0] mask_w(input logic [8:0] w, input logic [1:0] s);
    return w & ((9'h1 << nbits(s)) - 9'h1);
  endfunction

  task automatic line(input logic v, input int ticks);
    rx <= v;
    repeat (ticks * ((div == 0) ? 1 : int'(div))) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] w, input bit bad_par, input bit bad_stop, input int extra_low);
    logic [8:0] m;
    logic p;
    m = mask_w(w, wsel);
    p = ^m ^ podd ^ bad_par;
    line(1'b0, 16);
    for (int i = 0; i < nbits(wsel); i++) line(m[i], 16);
    if (pen) line(p, 16);
    if (bad_stop) line(1'b0, stop_ticks(ssel) + extra_low * 16);
    else          line(1'b1, stop_ticks(ssel));
    line(1'b1, 32);
  endtask

  task automatic frame(input logic [8:0] w, input bit bad_par, input bit bad_stop, input int extra_low);
    logic [8:0] m;
    m = mask_w(w, wsel);
    vcnt = 0;
    send(w, bad_par, bad_stop, extra_low);
    check("R8 pulse count", 9'(vcnt), 9'd1);
    check("R4 word", cap_w, m);
    check("R5 parity_err", {8'd0, cap_p}, {8'd0, pen & bad_par});
    check("R6 frame_err", {8'd0, cap_f}, {8'd0, bad_stop});
    check("R9 eop", {8'd0, cap_e}, {8'd0, m == term});
    check("R8 word held", word, m);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 valid", {8'd0, valid}, 9'd0);
    check("R1 word", word, 9'd0);
    check("R1 flags", {6'd0, perr, ferr, eop}, 9'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R4 directed: 8-bit LSB first, R9 terminator line feed
    frame(9'h00A, 0, 0, 0);
    // R4 9-bit, R6 1.5 stop, R5 odd parity
    wsel = 2'd2; ssel = 2'd1; pen = 1; podd = 1; term = 9'h1FF;
    frame(9'h1FF, 0, 0, 0);
    frame(9'h155, 1, 0, 0);
    // R4 7-bit masking, R6 two stops with error
    wsel = 2'd0; ssel = 2'd2; pen = 0; term = 9'h00D;
    frame(9'h18D, 0, 0, 0);
    frame(9'h041, 0, 1, 0);
    // R7: line held low long after bad stop yields no extra word
    frame(9'h022, 0, 1, 20);
    frame(9'h033, 0, 0, 0);
    // R2: short low glitch is no start
    vcnt = 0;
    line(1'b0, 4);
    line(1'b1, 200);
    check("R2 false start", 9'(vcnt), 9'd0);
    // R3: divisor 0 behaves as 1
    div = 16'd0; wsel = 2'd1; ssel = 2'd0;
    frame(9'h0C3, 0, 0, 0);

    // random mix, fixed seed
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 70; k++) begin
      logic [8:0] w;
      int r;
      div  = 16'($urandom_range(1, 5));
      wsel = 2'($urandom_range(0, 3));
      ssel = 2'($urandom_range(0, 3));
      pen  = 1'($urandom_range(0, 1));
      podd = 1'($urandom_range(0, 1));
      w    = 9'($urandom);
      r    = $urandom_range(0, 5);
      term = (r == 0) ? 9'h00A : (r == 1) ? 9'h00D : (r == 2) ? 9'h000 :
             (r == 3) ? 9'h0FF : mask_w(w, wsel);
      line(1'b1, 16);
      frame(w, ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule